// File: doc/BRIEF.md
# Configuration Request TLP Packer

This block takes one configuration-space access at a time from a host-side requester and turns it into a three-dword PCIe configuration request header. It streams that header onto a 64-bit transmit stream with start and end markers. Each request names a bus, a device/function, a byte offset, an access size of one, two or four bytes, and write data. Before anything is sent, the block screens the target. Requests it refuses are answered locally with a status code and read data.

The block keeps its own copy of the root bus number. That copy selects type 0 requests (to the root bus) or type 1 requests (to any other bus). It is updated when a write to the primary-bus register of the root port completes successfully. After the last beat of a request is accepted, the block pulses a notice to the completion receiver. It then stays busy until that receiver reports the result.

Top module: `cfg_req_packer`

## Requirements
- R1: After reset, `req_ready` is 1, `tx_valid`, `rej_valid` and `sent_valid` are 0, and `root_bus_num` equals the parameter `ROOT_RST` (default 0).
- R2: Header dword 0 carries a length of 1 in bits 23:0. Its bits 31:24 carry the format/type byte: 0x04 for a read and 0x44 for a write when the target bus equals `root_bus_num`, and 0x05 for a read and 0x45 for a write otherwise.
- R3: Header dword 1 carries `root_bus_num` in bits 31:24, zero in bits 23:16, and a tag in bits 15:8. The tag is 0x1D for reads and 0x10 for writes. Bits 7:0 carry the byte enables.
- R4: `req_size` is coded 0 = one byte, 1 = two bytes, and 2 or 3 = four bytes. With lo = offset bits 1:0, the byte enables are 0x01<<lo for one byte, 0x03<<lo for two bytes, and 0x0F for four bytes (8 bits wide, so a two-byte access at lo=3 gives 0x18). Write data is masked to the access size and shifted left by 8*lo, keeping 32 bits.
- R5: Header dword 2 carries the bus in bits 31:24 and the devfn in bits 23:16. Bits 15:0 carry the offset with its two low bits forced to zero.
- R6: Each beat puts the first dword of its pair in `tx_data[31:0]` and the second in `tx_data[63:32]`. Beat 1 is {dw0, dw1}. For a read, or for a write whose offset bits 2:0 are not all zero, beat 2 is {dw2, data}, with data 0 for reads. That makes two beats.
- R7: A write whose offset bits 2:0 are zero takes three beats: {dw0, dw1}, then {dw2, 0}, then {data, 0}.
- R8: `tx_sop` is set only on the first beat and `tx_eop` only on the last. A beat and its markers hold steady while `tx_ready` is low, and no beat is dropped or reordered.
- R9: On the root bus, a devfn whose device field (bits 7:3) is non-zero is refused. A one-cycle `rej_valid` follows with `rej_code`=1 (not found), and no beat is sent. `rej_rdata` is 0xFFFFFFFF for a refused read and 0 for a refused write.
- R10: On any bus other than the root bus, a request is refused as not found (same outputs as R9) unless `link_state` equals `LINK_UP` (default 0x0F).
- R11: An access to offset 0x10 of devfn 0 on the root bus is refused with `rej_code`=2 (bad register) and `rej_rdata`=0. It is never sent.
- R12: `req_ready` is low from the accepting edge until `cpl_valid` arrives after the request has been sent. `sent_valid` pulses for one cycle right after the last beat is accepted, and `sent_write` gives the request's direction.
- R13: `root_bus_num` takes the low byte of the shifted write data only when a sent write to offset 0x18 on the root bus is answered with `cpl_valid` and `cpl_ok`=1. It is unchanged on `cpl_ok`=0 and ignores `cpl_valid` when no request is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | OFF_W | Byte offset in configuration space |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write value, right-aligned |
| link_state | input | LINK_W | Current link training state |
| tx_valid | output | 1 | Beat on `tx_data` is valid |
| tx_ready | input | 1 | Sink takes the beat |
| tx_data | output | 64 | Two header/data dwords |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |
| sent_valid | output | 1 | Request fully sent (pulse) |
| sent_write | output | 1 | Direction of the sent request |
| cpl_valid | input | 1 | Completion result from receiver |
| cpl_ok | input | 1 | Completion was successful |
| rej_valid | output | 1 | Local refusal (pulse) |
| rej_code | output | 2 | 1 = not found, 2 = bad register |
| rej_rdata | output | 32 | Read data returned with a refusal |
| root_bus_num | output | 8 | Current root bus number |

## Verification
The bench targets the quadword-alignment split, including a write whose offset is 4-byte but not 8-byte aligned. A design that tested only bits 1:0 would emit three beats there instead of two. It drives two-byte accesses at offset lo=3 and one-byte accesses at lo=1, where a byte-enable field truncated to four bits, or an unshifted data word, shows up as a wrong header dword or a wrong data dword. It also moves the root bus with a write to 0x18. Afterwards it checks that type selection, the requester ID and the link filter all follow the new number, and that a failed completion or a stray `cpl_valid` leaves the number unchanged. Back-pressure patterns expose a sender that advances or changes markers while `tx_ready` is low.

// File: rtl/cfgpk_pkg.sv
package cfgpk_pkg;
  localparam int DW        = 32;
  localparam int BEAT_W    = 2 * DW;
  localparam int MAX_BEATS = 3;
  localparam int IDX_W     = $clog2(MAX_BEATS);

  typedef enum logic [1:0] {
    RC_NONE      = 2'd0,
    RC_NOT_FOUND = 2'd1,
    RC_BAD_REG   = 2'd2
  } rej_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2
  } state_e;

  // byte-lane enables for a size code and the low address bits
  function automatic logic [7:0] byte_en_f(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'd0:    return 8'h01 << lo;
      2'd1:    return 8'h03 << lo;
      default: return 8'h0F;
    endcase
  endfunction

  // write data masked to the access size and moved to its lanes
  function automatic logic [DW-1:0] place_data_f(input logic [1:0] sz, input logic [1:0] lo,
                                                 input logic [DW-1:0] wd);
    logic [DW-1:0] m;
    case (sz)
      2'd0:    m = {24'h0, wd[7:0]};
      2'd1:    m = {16'h0, wd[15:0]};
      default: m = wd;
    endcase
    if (sz == 2'd0 || sz == 2'd1) return m << {lo, 3'b000};
    return m;
  endfunction

  // format/type byte: write sets bit 6, type 1 sets bit 0
  function automatic logic [7:0] fmt_type_f(input logic wr, input logic type1);
    return {1'b0, wr, 3'b000, 1'b1, 1'b0, type1};
  endfunction
endpackage

// File: rtl/cfgpk_target_filter.sv
module cfgpk_target_filter
  import cfgpk_pkg::*;
#(
  parameter int          OFF_W   = 12,
  parameter int          LINK_W  = 5,
  parameter logic [LINK_W-1:0] LINK_UP = 5'h0F,
  parameter logic [OFF_W-1:0]  BAR_OFF = 12'h010
) (
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFF_W-1:0] offset,
  input  logic             is_write,
  input  logic [LINK_W-1:0] link_state,
  input  logic [7:0]       root_bus,
  output logic             reject,
  output rej_code_e        code,
  output logic [DW-1:0]    rdata
);
  logic on_root, bar_hit, dev_bad, link_bad;

  assign on_root  = (bus == root_bus);
  assign bar_hit  = on_root && (devfn == 8'h00) && (offset == BAR_OFF);
  assign dev_bad  = on_root && (devfn[7:3] != 5'd0);
  assign link_bad = !on_root && (link_state != LINK_UP);

  always_comb begin
    reject = 1'b0;
    code   = RC_NONE;
    rdata  = '0;
    if (bar_hit) begin
      reject = 1'b1;
      code   = RC_BAD_REG;
    end else if (dev_bad || link_bad) begin
      reject = 1'b1;
      code   = RC_NOT_FOUND;
      rdata  = is_write ? '0 : '1;
    end
  end
endmodule

// File: rtl/cfgpk_hdr_builder.sv
module cfgpk_hdr_builder
  import cfgpk_pkg::*;
#(
  parameter int         OFF_W  = 12,
  parameter logic [7:0] RD_TAG = 8'h1D,
  parameter logic [7:0] WR_TAG = 8'h10
) (
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFF_W-1:0] offset,
  input  logic [1:0]       size,
  input  logic             is_write,
  input  logic [DW-1:0]    wdata,
  input  logic [7:0]       root_bus,
  output logic [MAX_BEATS-1:0][BEAT_W-1:0] beats,
  output logic [IDX_W-1:0] last_idx,
  output logic [7:0]       data_lo
);
  localparam int PAD_W = 16 - OFF_W;

  logic [DW-1:0]   dw0, dw1, dw2, data;
  logic [OFF_W-1:0] off_al;
  logic            qw_split;

  assign data     = is_write ? place_data_f(size, offset[1:0], wdata) : '0;
  assign data_lo  = data[7:0];
  assign off_al   = {offset[OFF_W-1:2], 2'b00};
  assign dw0      = {fmt_type_f(is_write, bus != root_bus), 24'd1};
  assign dw1      = {root_bus, 8'h00, is_write ? WR_TAG : RD_TAG,
                     byte_en_f(size, offset[1:0])};
  assign dw2      = {bus, devfn, {PAD_W{1'b0}}, off_al};
  assign qw_split = is_write && (offset[2:0] == 3'b000);

  always_comb begin
    beats[0] = {dw1, dw0};
    if (qw_split) begin
      beats[1] = {{DW{1'b0}}, dw2};
      beats[2] = {{DW{1'b0}}, data};
      last_idx = IDX_W'(2);
    end else begin
      beats[1] = {data, dw2};
      beats[2] = '0;
      last_idx = IDX_W'(1);
    end
  end
endmodule

// File: rtl/cfgpk_beat_tx.sv
module cfgpk_beat_tx
  import cfgpk_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           load,
  input  logic [MAX_BEATS-1:0][BEAT_W-1:0] beats_in,
  input  logic [IDX_W-1:0]               last_in,
  input  logic                           tx_ready,
  output logic                           tx_valid,
  output logic [BEAT_W-1:0]              tx_data,
  output logic                           tx_sop,
  output logic                           tx_eop,
  output logic                           tx_last_fire
);
  logic [BEAT_W-1:0] store [MAX_BEATS];
  logic [IDX_W-1:0]  idx, last_q;
  logic              active, fire;

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_beat
    always_ff @(posedge clk) begin
      if (!rst_n)    store[g] <= '0;
      else if (load) store[g] <= beats_in[g];
    end
  end

  assign tx_valid     = active;
  assign tx_data      = store[idx];
  assign tx_sop       = active && (idx == '0);
  assign tx_eop       = active && (idx == last_q);
  assign fire         = active && tx_ready;
  assign tx_last_fire = fire && (idx == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      last_q <= '0;
    end else if (load) begin
      active <= 1'b1;
      idx    <= '0;
      last_q <= last_in;
    end else if (fire) begin
      if (idx == last_q) active <= 1'b0;
      else               idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/cfgpk_root_tracker.sv
module cfgpk_root_tracker #(
  parameter logic [7:0] ROOT_RST = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [7:0] new_bus,
  output logic [7:0] root_bus
);
  always_ff @(posedge clk) begin
    if (!rst_n)   root_bus <= ROOT_RST;
    else if (upd) root_bus <= new_bus;
  end
endmodule

// File: rtl/cfg_req_packer.sv
module cfg_req_packer
  import cfgpk_pkg::*;
#(
  parameter int              OFF_W    = 12,
  parameter int              LINK_W   = 5,
  parameter logic [LINK_W-1:0] LINK_UP = 5'h0F,
  parameter logic [OFF_W-1:0]  BAR_OFF = 12'h010,
  parameter logic [OFF_W-1:0]  PRIM_OFF = 12'h018,
  parameter logic [7:0]      RD_TAG   = 8'h1D,
  parameter logic [7:0]      WR_TAG   = 8'h10,
  parameter logic [7:0]      ROOT_RST = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [7:0]        req_bus,
  input  logic [7:0]        req_devfn,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic [LINK_W-1:0] link_state,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [63:0]       tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic              sent_valid,
  output logic              sent_write,
  input  logic              cpl_valid,
  input  logic              cpl_ok,
  output logic              rej_valid,
  output logic [1:0]        rej_code,
  output logic [31:0]       rej_rdata,
  output logic [7:0]        root_bus_num
);
  state_e    st;
  logic      acc_fire, acc_reject, tx_last_fire, root_upd, load;
  rej_code_e flt_code;
  logic [DW-1:0] flt_rdata;
  logic [MAX_BEATS-1:0][BEAT_W-1:0] beats;
  logic [IDX_W-1:0] last_idx;
  logic [7:0] data_lo, pend_byte;
  logic       pend_prim, prim_hit;

  assign req_ready = (st == ST_IDLE);
  assign acc_fire  = req_valid && req_ready;
  assign load      = acc_fire && !acc_reject;
  assign prim_hit  = req_write && (req_bus == root_bus_num) && (req_offset == PRIM_OFF);
  assign root_upd  = (st == ST_WAIT) && cpl_valid && cpl_ok && pend_prim;

  cfgpk_target_filter #(
    .OFF_W(OFF_W), .LINK_W(LINK_W), .LINK_UP(LINK_UP), .BAR_OFF(BAR_OFF)
  ) u_filter (
    .bus(req_bus), .devfn(req_devfn), .offset(req_offset), .is_write(req_write),
    .link_state(link_state), .root_bus(root_bus_num),
    .reject(acc_reject), .code(flt_code), .rdata(flt_rdata)
  );

  cfgpk_hdr_builder #(
    .OFF_W(OFF_W), .RD_TAG(RD_TAG), .WR_TAG(WR_TAG)
  ) u_hdr (
    .bus(req_bus), .devfn(req_devfn), .offset(req_offset), .size(req_size),
    .is_write(req_write), .wdata(req_wdata), .root_bus(root_bus_num),
    .beats(beats), .last_idx(last_idx), .data_lo(data_lo)
  );

  cfgpk_beat_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(load), .beats_in(beats), .last_in(last_idx),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_last_fire(tx_last_fire)
  );

  cfgpk_root_tracker #(.ROOT_RST(ROOT_RST)) u_root (
    .clk(clk), .rst_n(rst_n), .upd(root_upd), .new_bus(pend_byte),
    .root_bus(root_bus_num)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      rej_valid  <= 1'b0;
      rej_code   <= RC_NONE;
      rej_rdata  <= '0;
      sent_valid <= 1'b0;
      sent_write <= 1'b0;
      pend_prim  <= 1'b0;
      pend_byte  <= '0;
    end else begin
      rej_valid  <= 1'b0;
      sent_valid <= tx_last_fire;
      case (st)
        ST_IDLE: if (acc_fire) begin
          if (acc_reject) begin
            rej_valid <= 1'b1;
            rej_code  <= flt_code;
            rej_rdata <= flt_rdata;
          end else begin
            st         <= ST_SEND;
            sent_write <= req_write;
            pend_prim  <= prim_hit;
            pend_byte  <= data_lo;
          end
        end
        ST_SEND: if (tx_last_fire) st <= ST_WAIT;
        ST_WAIT: if (cpl_valid) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgpk_checker.sv
module cfgpk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [63:0] tx_data,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        sent_valid,
  input logic        rej_valid,
  input logic [1:0]  rej_code,
  input logic [31:0] rej_rdata,
  input logic [7:0]  root_bus_num,
  input logic        acc_fire,
  input logic        acc_reject,
  input logic        tx_last_fire,
  input logic        root_upd
);
  // R8: a stalled beat keeps data and markers
  p_hold_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sop) && $stable(tx_eop));

  // R8: a sent request opens with the start marker
  p_start_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire && !acc_reject |=> tx_valid && tx_sop);

  // R12: no new request while beats are in flight
  p_busy_sending_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  // R12: notice follows the last accepted beat
  p_sent_after_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last_fire |=> sent_valid && !tx_valid && !req_ready);

  // R9: refused requests produce a refusal and no beat
  p_reject_no_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_reject && acc_fire |=> rej_valid && !tx_valid);

  // R11: bad-register refusal carries zero data
  p_bar_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid && rej_code == 2'd2 |-> rej_rdata == 32'h0);

  // R13: root bus moves only on a qualifying completion
  p_root_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !root_upd |=> $stable(root_bus_num));
endmodule

bind cfg_req_packer cfgpk_checker u_chk (.*);

// File: tb/tb_cfg_req_packer.sv
`timescale 1ns/1ps
module tb_cfg_req_packer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic req_ready;
  logic [7:0] req_bus = 0, req_devfn = 0;
  logic [11:0] req_offset = 0;
  logic [1:0] req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [4:0] link_state = 0;
  logic tx_valid, tx_sop, tx_eop, tx_ready = 0;
  logic [63:0] tx_data;
  logic sent_valid, sent_write;
  logic cpl_valid = 0, cpl_ok = 0;
  logic rej_valid;
  logic [1:0] rej_code;
  logic [31:0] rej_rdata;
  logic [7:0] root_bus_num;

  int n_checks = 0, n_fail = 0;
  logic [7:0] rb = 8'h00;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_req_packer dut (.*);

  // {bp, wr, bus, devfn, off, size, wdata, link}
  localparam int NV = 14;
  localparam logic [68:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0,         5'h00}, // R2 type0 read
    {1'b1, 1'b0, 8'h00, 8'h00, 12'h006, 2'd1, 32'h0,         5'h00}, // R4 half lo2
    {1'b0, 1'b0, 8'h00, 8'h00, 12'h003, 2'd0, 32'h0,         5'h00}, // R4 byte lo3
    {1'b0, 1'b0, 8'h00, 8'h00, 12'h007, 2'd1, 32'h0,         5'h00}, // R4 half lo3 -> 0x18
    {1'b1, 1'b1, 8'h00, 8'h00, 12'h004, 2'd2, 32'hA5A51234,  5'h00}, // R6 4-aligned write
    {1'b0, 1'b1, 8'h00, 8'h00, 12'h009, 2'd0, 32'hCC77,      5'h00}, // R6 byte lo1
    {1'b1, 1'b1, 8'h00, 8'h00, 12'h020, 2'd1, 32'h1234BEEF,  5'h00}, // R7 aligned write
    {1'b0, 1'b0, 8'h03, 8'h08, 12'h104, 2'd2, 32'h0,         5'h0F}, // R10 type1 read
    {1'b1, 1'b1, 8'h03, 8'h11, 12'h040, 2'd3, 32'hDEADBEEF,  5'h0F}, // R7 type1 write
    {1'b0, 1'b0, 8'h03, 8'h00, 12'h000, 2'd2, 32'h0,         5'h0E}, // R10 link down
    {1'b0, 1'b0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0,         5'h0F}, // R9 dev 1 read
    {1'b0, 1'b1, 8'h00, 8'h10, 12'h000, 2'd2, 32'h1,         5'h0F}, // R9 dev 2 write
    {1'b0, 1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0,         5'h0F}, // R11 bar read
    {1'b0, 1'b0, 8'h00, 8'h00, 12'h011, 2'd0, 32'h0,         5'h0F}  // R11 near bar allowed
  };

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_be(input logic [1:0] sz, input logic [1:0] lo);
    if (sz == 2'd0) return 8'(1 << lo);
    if (sz == 2'd1) return 8'(3 << lo);
    return 8'h0F;
  endfunction

  function automatic logic [31:0] m_dat(input logic [1:0] sz, input logic [1:0] lo,
                                        input logic [31:0] wd);
    logic [63:0] t;
    if (sz == 2'd0)      t = 64'(wd[7:0]) << (8 * lo);
    else if (sz == 2'd1) t = 64'(wd[15:0]) << (8 * lo);
    else                 t = 64'(wd);
    return t[31:0];
  endfunction

  task automatic do_req(input logic bp, input logic wr, input logic [7:0] bus,
                        input logic [7:0] devfn, input logic [11:0] off,
                        input logic [1:0] sz, input logic [31:0] wd,
                        input logic [4:0] link, input logic ok, input string tag);
    logic [63:0] e [3];
    logic [63:0] g [3];
    logic gs [3];
    logic ge [3];
    int ne, n, cyc;
    logic [31:0] dw0, dw1, dw2, dat;
    logic [7:0] fmt;
    logic [1:0] ecode;
    logic [31:0] erd;
    logic bad, nf, got_end;
    bad = (bus == rb) && (devfn == 8'h00) && (off == 12'h010);
    nf  = !bad && (((bus == rb) && (devfn[7:3] != 0)) || ((bus != rb) && (link != 5'h0F)));
    ecode = bad ? 2'd2 : 2'd1;
    erd   = (nf && !wr) ? 32'hFFFFFFFF : 32'h0;
    fmt = wr ? ((bus != rb) ? 8'h45 : 8'h44) : ((bus != rb) ? 8'h05 : 8'h04);
    dat = wr ? m_dat(sz, off[1:0], wd) : 32'h0;
    dw0 = {fmt, 24'h000001};
    dw1 = {rb, 8'h00, wr ? 8'h10 : 8'h1D, m_be(sz, off[1:0])};
    dw2 = {bus, devfn, 4'h0, off[11:2], 2'b00};
    e[0] = {dw1, dw0};
    if (wr && off[2:0] == 3'b000) begin
      e[1] = {32'h0, dw2}; e[2] = {32'h0, dat}; ne = 3;
    end else begin
      e[1] = {dat, dw2}; e[2] = 64'h0; ne = 2;
    end

    @(negedge clk);
    req_write = wr; req_bus = bus; req_devfn = devfn; req_offset = off;
    req_size = sz; req_wdata = wd; link_state = link; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (bad || nf) begin
      chk(rej_valid == 1'b1, tag, "refusal pulse", 64'(rej_valid), 64'd1);
      chk(rej_code == ecode, tag, "refusal code", 64'(rej_code), 64'(ecode));
      chk(rej_rdata == erd, tag, "refusal data", 64'(rej_rdata), 64'(erd));
      chk(tx_valid == 1'b0, tag, "nothing sent", 64'(tx_valid), 64'd0);
      @(negedge clk);
      chk(rej_valid == 1'b0 && tx_valid == 1'b0, tag, "refusal one cycle",
          64'({rej_valid, tx_valid}), 64'd0);
      return;
    end
    n = 0; cyc = 0; got_end = 1'b0;
    while (!got_end && cyc < 40) begin
      tx_ready = bp ? cyc[0] : 1'b1;
      #1;
      if (tx_valid && tx_ready) begin
        if (n < 3) begin g[n] = tx_data; gs[n] = tx_sop; ge[n] = tx_eop; end
        n++;
        got_end = tx_eop;
      end
      @(negedge clk);
      cyc++;
    end
    tx_ready = 1'b0;
    chk(n == ne, tag, "beat count", 64'(n), 64'(ne));
    for (int i = 0; i < ne && i < n && i < 3; i++) begin
      chk(g[i] == e[i], tag, $sformatf("beat %0d data", i), g[i], e[i]);
      chk(gs[i] == (i == 0) && ge[i] == (i == ne - 1), "R8",
          $sformatf("%s beat %0d markers", tag, i), 64'({gs[i], ge[i]}),
          64'({i == 0, i == ne - 1}));
    end
    chk(sent_valid == 1'b1 && sent_write == wr, "R12", "sent notice",
        64'({sent_valid, sent_write}), 64'({1'b1, wr}));
    @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b0 && tx_valid == 1'b0 && sent_valid == 1'b0, "R12",
        "busy while waiting", 64'({req_ready, tx_valid, sent_valid}), 64'd0);
    req_valid = 1'b0;
    cpl_valid = 1'b1; cpl_ok = ok;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_ok = 1'b0;
    if (ok && wr && bus == rb && off == 12'h018) rb = dat[7:0];
    chk(root_bus_num == rb, "R13", "root bus after completion", 64'(root_bus_num), 64'(rb));
    chk(req_ready == 1'b1, "R12", "idle after completion", 64'(req_ready), 64'd1);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1 && tx_valid == 0 && rej_valid == 0 && sent_valid == 0, "R1",
        "outputs in reset", 64'({req_ready, tx_valid, rej_valid, sent_valid}), 64'h8);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1 && tx_valid == 0 && root_bus_num == 8'h00, "R1", "state after reset",
        64'({req_ready, tx_valid, root_bus_num}), 64'h200);

    for (int v = 0; v < NV; v++) begin
      logic [68:0] x;
      x = VEC[v];
      do_req(x[68], x[67], x[66:59], x[58:51], x[50:39], x[38:37], x[36:5], x[4:0],
             1'b1, $sformatf("vec%0d R2 R3 R5", v));
    end

    // R13: stray completion while idle is ignored
    @(negedge clk);
    cpl_valid = 1'b1; cpl_ok = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0; cpl_ok = 1'b0;
    @(negedge clk);
    chk(root_bus_num == 8'h00 && req_ready == 1'b1, "R13", "idle completion ignored",
        64'({root_bus_num, req_ready}), 64'h001);

    // R13: failed completion leaves root bus
    do_req(1'b0, 1'b1, 8'h00, 8'h00, 12'h018, 2'd0, 32'h05, 5'h00, 1'b0, "R13 failed write");
    chk(root_bus_num == 8'h00, "R13", "no update on error", 64'(root_bus_num), 64'h0);
    // R13: successful write moves the root bus
    do_req(1'b1, 1'b1, 8'h00, 8'h00, 12'h018, 2'd0, 32'hA05, 5'h00, 1'b1, "R13 primary write");
    chk(root_bus_num == 8'h05, "R13", "root updated", 64'(root_bus_num), 64'h05);
    // R2 R3: bus 5 now type 0 with new requester ID
    do_req(1'b0, 1'b0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0, 5'h00, 1'b1, "R2 R3 new root");
    // R10: old root bus now needs the link
    do_req(1'b0, 1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 5'h01, 1'b1, "R10 old root link down");
    // R11: bar on new root bus
    do_req(1'b0, 1'b1, 8'h05, 8'h00, 12'h010, 2'd2, 32'h7, 5'h0F, 1'b1, "R11 bar write");
    // R13: 0x18 on a non-root bus does not move root
    do_req(1'b0, 1'b1, 8'h09, 8'h00, 12'h018, 2'd2, 32'h33, 5'h0F, 1'b1, "R13 non-root 0x18");
    chk(root_bus_num == 8'h05, "R13", "non-root write no update", 64'(root_bus_num), 64'h05);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule